// File: doc/BRIEF.md
# Conversion Sequence Trigger Controller

This block decides when a multi-channel conversion sequence begins. Software programs a 32-bit control word that holds five fields: an enable, a trigger polarity select, a synchronizer bypass, a one-shot software start and a continuous-repeat (burst) mode. A hardware trigger line passes through an optional chain of synchronizer flops. A polarity-selectable edge detector then watches it.

When a start condition is met, the block emits a one-cycle `seq_start` pulse to a downstream sequencer. It then holds `busy` until the sequencer answers with `seq_done`. While `busy` is high, the block launches nothing new.

In burst mode, the block relaunches the sequence each time it completes and pays no attention to the trigger line. When burst is cleared, the pass in flight still runs to its end and no further pass follows. Any write to the control word blanks edge detection for the next cycle. This keeps a change of polarity, bypass or enable from being mistaken for a trigger edge.

Top module: `seq_trig_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0, `seq_start` is 0 and `busy` is 0.
- R2: Control word fields read back as written: enable at bit 31, burst at bit 27, bypass at bit 19, polarity at bit 18. Bit 26 (start), bits 25:20 and every other bit always read 0.
- R3: Writing bit 26 = 1 together with bit 31 = 1 while idle makes `seq_start` high in the cycle after the write edge. `busy` rises in that same cycle.
- R4: While the enable bit is 0, no software start, hardware edge or burst setting produces `seq_start`.
- R5: With polarity bit = 1 a rising trigger edge starts a pass, and a falling edge does not. With polarity bit = 0 a falling edge starts a pass, and a rising edge does not.
- R6: With bypass = 1, a trigger change driven in one cycle gives `seq_start` in the next cycle. With bypass = 0, it gives `seq_start` three cycles after it is driven (two synchronizer stages).
- R7: A control write never starts a pass by itself, whatever it changes. A trigger edge that arrives in the cycle right after a write is not detected.
- R8: `busy` stays high from the start pulse until `seq_done` is seen. A hardware edge or software start that arrives while `busy` is high is dropped. This includes one that arrives in the same cycle as `seq_done`.
- R9: While burst and enable are set, the block relaunches automatically. After `busy` falls there is one idle cycle, then `seq_start` follows. Hardware edges add no pass.
- R10: Clearing burst while a pass runs lets that pass complete (`busy` falls on `seq_done`). No further `seq_start` follows.
- R11: A software start and a qualifying hardware edge in the same cycle produce exactly one `seq_start` pulse.
- R12: `seq_start` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| trig_in | input | 1 | Hardware trigger line |
| seq_done | input | 1 | Sequencer reports pass complete |
| seq_start | output | 1 | One-cycle pass launch pulse |
| busy | output | 1 | A pass is in flight |

## Verification
Two events can collide in one cycle. A qualifying trigger edge can coincide with the sequencer's `seq_done`, or a software start write can coincide with a hardware edge. The bench provokes the first by driving `seq_done` and a bypassed rising trigger at the same falling clock edge. It expects `busy` to clear with no new pass afterwards. For the second, it issues the start write and the trigger rise together and expects a start count that has grown by exactly one once the pass has drained.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

    localparam int CTRL_W    = 32;
    localparam int BIT_EN    = 31;
    localparam int BIT_BURST = 27;
    localparam int BIT_START = 26;
    localparam int BIT_BYP   = 19;
    localparam int BIT_POL   = 18;

    typedef struct packed {
        logic en;
        logic burst;
        logic byp;
        logic pol;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic mask;
    } ctl_t;

    typedef struct packed {
        logic busy;
        logic start;
    } run_t;

    function automatic cfg_t cfg_decode(input logic [CTRL_W-1:0] w);
        cfg_t c;
        c.en    = w[BIT_EN];
        c.burst = w[BIT_BURST];
        c.byp   = w[BIT_BYP];
        c.pol   = w[BIT_POL];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] cfg_encode(input cfg_t c);
        logic [CTRL_W-1:0] w;
        w            = '0;
        w[BIT_EN]    = c.en;
        w[BIT_BURST] = c.burst;
        w[BIT_BYP]   = c.byp;
        w[BIT_POL]   = c.pol;
        return w;
    endfunction

endpackage

// File: rtl/seqtrig_sync.sv
module seqtrig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic bypass,
    output logic q
);
    logic [STAGES-1:0] s_d, s_q;

    always_comb begin
        s_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d[i] = s_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Bypass hands the raw line straight to the edge detector.
    assign q = bypass ? d : s_q[STAGES-1];
endmodule

// File: rtl/seqtrig_edge.sv
module seqtrig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    input  logic arm,
    output logic hit
);
    logic prev_d, prev_q;

    // History always follows the selected level, so a later change of
    // polarity reinterprets a steady line and never sees an edge.
    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign hit = arm & (rise_sel ? (level & ~prev_q) : (~level & prev_q));
endmodule

// File: rtl/seqtrig_launch.sv
module seqtrig_launch
    import seqtrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    input  logic burst_next,
    input  logic sw_go,
    input  logic hw_hit,
    input  logic done,
    output logic start,
    output logic busy
);
    run_t r_d, r_q;
    logic go;

    always_comb begin
        // Burst masks the hardware edge; software start is still accepted.
        go = ~r_q.busy & en_next & (burst_next | sw_go | (hw_hit & ~burst_next));
        r_d.start = go;
        r_d.busy  = go | (r_q.busy & ~done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign start = r_q.start;
    assign busy  = r_q.busy;
endmodule

// File: rtl/seq_trig_ctrl.sv
module seq_trig_ctrl
    import seqtrig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              trig_in,
    input  logic              seq_done,
    output logic              seq_start,
    output logic              busy
);
    ctl_t ctl_d, ctl_q;
    logic sw_go;
    logic trig_lvl;
    logic hw_hit;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mask = wr_en;
        if (wr_en) ctl_d.cfg = cfg_decode(wr_data);
        sw_go = wr_en & wr_data[BIT_START];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    seqtrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (trig_in),
        .bypass (ctl_q.cfg.byp),
        .q      (trig_lvl)
    );

    seqtrig_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (trig_lvl),
        .rise_sel (ctl_q.cfg.pol),
        .arm      (ctl_q.cfg.en & ~ctl_q.mask),
        .hit      (hw_hit)
    );

    seqtrig_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_next    (ctl_d.cfg.en),
        .burst_next (ctl_d.cfg.burst),
        .sw_go      (sw_go),
        .hw_hit     (hw_hit),
        .done       (seq_done),
        .start      (seq_start),
        .busy       (busy)
    );

    assign rd_data = cfg_encode(ctl_q.cfg);
endmodule

// File: rtl/seq_trig_ctrl_chk.sv
module seq_trig_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        seq_done,
    input logic        seq_start,
    input logic        busy
);
    assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);

    assert_drop_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done && !seq_start) |=> !seq_start);

    assert_start_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> rd_data[31]);

    assert_hidden_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[26] == 1'b0) && (rd_data[25:20] == 6'd0));

    assert_burst_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[27] && rd_data[31] && !busy && !wr_en) |=> seq_start);
endmodule

bind seq_trig_ctrl seq_trig_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .seq_done  (seq_done),
    .seq_start (seq_start),
    .busy      (busy)
);

// File: tb/tb_seq_trig_ctrl.sv
module tb_seq_trig_ctrl;
    localparam int CLK_P = 10;
    localparam logic [31:0] F_EN    = 32'h8000_0000;
    localparam logic [31:0] F_BURST = 32'h0800_0000;
    localparam logic [31:0] F_START = 32'h0400_0000;
    localparam logic [31:0] F_BYP   = 32'h0008_0000;
    localparam logic [31:0] F_POL   = 32'h0004_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic trig_in = 1'b0;
    logic seq_start, busy;
    logic seq_done;
    logic done_r = 1'b0;
    logic manual_done = 1'b0;
    logic stub_on = 1'b1;
    int   stub_cnt = 0;
    int   n_start = 0;
    int   checks = 0;
    int   errors = 0;

    always #(CLK_P/2) clk = ~clk;

    assign seq_done = done_r | manual_done;

    seq_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .trig_in(trig_in), .seq_done(seq_done),
        .seq_start(seq_start), .busy(busy)
    );

    // Sequencer stub: done pulse a few cycles after each start.
    always @(posedge clk) begin
        done_r <= (stub_cnt == 1);
        if (seq_start && stub_on) stub_cnt <= 3;
        else if (stub_cnt != 0)   stub_cnt <= stub_cnt - 1;
        if (rst_n && seq_start) n_start <= n_start + 1;
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && busy; i++) cyc();
    endtask

    task automatic t_reset();
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        chk(seq_start == 0 && busy == 0, "R1 outputs", {seq_start, busy}, 0);
    endtask

    task automatic t_readback();
        int base;
        base = n_start;
        wr(32'h7FFF_FFFF);
        chk(rd_data == 32'h080C_0000, "R2 readback", rd_data, 32'h080C_0000);
        trig_in = 1'b1; cyc(2); trig_in = 1'b0; cyc(3);
        chk(n_start == base, "R4 disabled burst/start/edge", n_start, base);
        wr(F_POL | F_BYP); cyc();
        trig_in = 1'b1; cyc(3);
        chk(n_start == base, "R4 disabled hw edge", n_start, base);
        trig_in = 1'b0;
        wr(0);
        chk(rd_data == 0, "R2 cleared", rd_data, 0);
    endtask

    task automatic t_sw_start();
        wr(F_EN | F_START);
        chk(seq_start == 1 && busy == 1, "R3 start and busy", {seq_start, busy}, 2'b11);
        chk(rd_data == F_EN, "R2 start reads 0", rd_data, F_EN);
        cyc();
        chk(seq_start == 0, "R12 one-cycle pulse", seq_start, 0);
        chk(busy == 1, "R8 busy held", busy, 1);
        wait_idle();
        chk(busy == 0, "R8 busy clears on done", busy, 0);
    endtask

    task automatic t_polarity();
        int base;
        wr(F_EN | F_POL | F_BYP); cyc();
        trig_in = 1'b1; cyc();
        chk(seq_start == 1, "R5 rising with pol 1", seq_start, 1);
        wait_idle(); cyc();
        base = n_start;
        trig_in = 1'b0; cyc(3);
        chk(n_start == base, "R5 falling ignored pol 1", n_start, base);
        wr(F_EN | F_BYP); cyc(2);
        chk(n_start == base, "R7 pol change no spurious", n_start, base);
        trig_in = 1'b1; cyc(2);
        chk(n_start == base, "R5 rising ignored pol 0", n_start, base);
        trig_in = 1'b0; cyc();
        chk(seq_start == 1, "R5 falling with pol 0", seq_start, 1);
        wait_idle(); cyc();
    endtask

    task automatic t_latency();
        wr(F_EN | F_POL); cyc();
        trig_in = 1'b1;
        cyc(); chk(seq_start == 0, "R6 sync cycle 1", seq_start, 0);
        cyc(); chk(seq_start == 0, "R6 sync cycle 2", seq_start, 0);
        cyc(); chk(seq_start == 1, "R6 sync cycle 3", seq_start, 1);
        wait_idle();
        trig_in = 1'b0; cyc(3);
    endtask

    task automatic t_masked();
        int base;
        base = n_start;
        wr(F_EN | F_POL | F_BYP);
        trig_in = 1'b1; cyc(3);
        chk(n_start == base, "R7 edge after write masked", n_start, base);
        wr(F_EN | F_POL); cyc(3);
        chk(n_start == base, "R7 bypass change no spurious", n_start, base);
        trig_in = 1'b0; cyc(3);
    endtask

    task automatic t_busy_drop();
        int base;
        stub_on = 1'b0;
        wr(F_EN | F_POL | F_BYP); cyc();
        base = n_start;
        trig_in = 1'b1; cyc(2);
        trig_in = 1'b0; cyc();
        trig_in = 1'b1; cyc(2);
        chk(n_start == base + 1 && busy == 1, "R8 edge while busy", n_start, base + 1);
        wr(F_EN | F_POL | F_BYP | F_START); cyc(2);
        chk(n_start == base + 1, "R8 start while busy", n_start, base + 1);
        trig_in = 1'b0; cyc(2);
        manual_done = 1'b1; trig_in = 1'b1;
        cyc();
        manual_done = 1'b0;
        cyc(3);
        chk(busy == 0 && n_start == base + 1, "R8 edge with done dropped", n_start, base + 1);
        trig_in = 1'b0; stub_on = 1'b1; cyc(2);
    endtask

    task automatic t_collide();
        int base;
        wr(F_EN | F_POL | F_BYP); cyc(2);
        base = n_start;
        wr_en = 1'b1; wr_data = F_EN | F_POL | F_BYP | F_START; trig_in = 1'b1;
        cyc();
        wr_en = 1'b0; wr_data = '0;
        chk(seq_start == 1, "R11 start issued", seq_start, 1);
        wait_idle(); cyc(3);
        chk(n_start == base + 1, "R11 single pulse", n_start, base + 1);
        trig_in = 1'b0; cyc(2);
    endtask

    task automatic t_burst();
        int base;
        base = n_start;
        wr(F_EN | F_BURST);
        chk(seq_start == 1, "R9 burst launches", seq_start, 1);
        for (int i = 0; i < 40 && busy; i++) begin
            trig_in = ~trig_in;
            cyc();
        end
        chk(busy == 0 && seq_start == 0, "R9 idle gap", {busy, seq_start}, 0);
        cyc();
        chk(seq_start == 1 && busy == 1, "R9 relaunch", {seq_start, busy}, 2'b11);
        cyc(30);
        chk(n_start >= base + 5, "R9 repeats", n_start, base + 5);
        for (int i = 0; i < 20 && !seq_start; i++) cyc();
        cyc();
        base = n_start;
        wr(F_EN);
        chk(busy == 1, "R10 pass still running", busy, 1);
        wait_idle();
        chk(busy == 0, "R10 pass completes", busy, 0);
        cyc(10);
        chk(n_start == base, "R10 no further pass", n_start, base);
        trig_in = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_readback();
        t_sw_start();
        t_polarity();
        t_latency();
        t_masked();
        t_busy_drop();
        t_collide();
        t_burst();
        summary();
        $finish;
    end
endmodule